// File: doc/BRIEF.md
# Interlaced Field Parity Detector

This block classifies each field of an interlaced video input, delivered with separate horizontal and vertical sync lines, as odd or even. It works from the timing of the vertical sync's leading edge relative to the most recent horizontal sync leading edge. A position counter restarts on every horizontal sync leading edge.

When a vertical sync leading edge arrives, the block checks the current position against a window. The window's two edges are each picked from four preset fractions of a programmed line length. A position inside the window marks an odd field and a position outside it marks an even field. An invert control swaps this reading.

The block presents the result as a level that holds between fields, and as a one-cycle pulse at the start of each field. Both sync inputs are asynchronous. Each passes through a two-stage synchronizer before edge detection. Streams that carry the field type inside the data are not handled here.

Top module: `field_parity_detector`

## Requirements
- R1: While `rst_n` is low and after it is released, `field_odd` and `field_start` are 0 until the first vertical sync leading edge is processed.
- R2: The measured position of a vertical sync leading edge is the number of clock cycles since the most recent horizontal sync leading edge, both taken at the input pins. A vertical edge that arrives in the same cycle as a horizontal edge has position 0.
- R3: Each window edge select maps code 0 to position 0, code 1 to floor(L/8), code 2 to floor(L/4) and code 3 to floor(L/2), where L is `line_len`.
- R4: With `invert` at 0, a position P satisfying start <= P < end gives `field_odd` = 1. Start is included and end is excluded.
- R5: With `invert` at 0, a position outside the window gives `field_odd` = 0. When end <= start, the window is empty and every position counts as outside.
- R6: With `invert` at 1, the result of R4 and R5 is reversed.
- R7: `field_start` is high for exactly one cycle, after the third rising clock edge that follows a rising `vsync_in`. `field_odd` takes its new value on that same edge.
- R8: `field_odd` changes only together with a `field_start` pulse. Falling vertical sync, vertical sync held high, and horizontal sync pulses without a vertical edge produce no pulse and leave `field_odd` unchanged.
- R9: Both syncs are active high. Only a 0-to-1 transition counts as a leading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous, active high |
| vsync_in | input | 1 | Vertical sync, asynchronous, active high |
| line_len | input | CNT_W | Line length in clocks, basis for window edges |
| win_start_sel | input | 2 | Preset code for window start |
| win_end_sel | input | 2 | Preset code for window end |
| invert | input | 1 | Swap odd/even interpretation |
| field_odd | output | 1 | Parity of the current field, 1 = odd |
| field_start | output | 1 | One-cycle pulse when a new field is classified |

## Verification
The assertions assume that `line_len`, the edge selects and `invert` are stable around each vertical sync leading edge. They also assume that a sync input, once it rises, stays high for at least two clocks, so that the synchronizer sees every leading edge. The stimulus changes configuration only while both syncs are low and well away from any edge. It holds each sync pulse for several cycles. Every vertical edge is placed a chosen number of clocks after a horizontal edge, so the expected position is known exactly. This includes positions on the window's start, its end, one short of each, and zero.

// File: rtl/field_parity_detector.sv
module field_parity_detector #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic [CNT_W-1:0] line_len,
  input  logic [1:0]       win_start_sel,
  input  logic [1:0]       win_end_sel,
  input  logic             invert,
  output logic             field_odd,
  output logic             field_start
);
  localparam logic [CNT_W-1:0] POS_MAX = '1;

  logic [2:0] hs_pipe, vs_pipe;
  logic hs_rise, vs_rise;
  logic [CNT_W-1:0] cnt, pos, start_pos, end_pos;
  logic in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_pipe <= '0;
      vs_pipe <= '0;
    end else begin
      hs_pipe <= {hs_pipe[1:0], hsync_in};
      vs_pipe <= {vs_pipe[1:0], vsync_in};
    end
  end

  assign hs_rise = hs_pipe[1] & ~hs_pipe[2];
  assign vs_rise = vs_pipe[1] & ~vs_pipe[2];

  assign pos = hs_rise ? '0 : (cnt == POS_MAX ? cnt : cnt + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= pos;
  end

  function automatic logic [CNT_W-1:0] edge_of(input logic [1:0] sel, input logic [CNT_W-1:0] len);
    case (sel)
      2'd0:    edge_of = '0;
      2'd1:    edge_of = len >> 3;
      2'd2:    edge_of = len >> 2;
      default: edge_of = len >> 1;
    endcase
  endfunction

  assign start_pos = edge_of(win_start_sel, line_len);
  assign end_pos   = edge_of(win_end_sel, line_len);
  assign in_win    = (pos >= start_pos) && (pos < end_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_odd   <= 1'b0;
      field_start <= 1'b0;
    end else begin
      field_start <= vs_rise;
      if (vs_rise) field_odd <= in_win ^ invert;
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> !field_start);

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |-> $stable(field_odd));

  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |=> (cnt == '0));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_rise && cnt != POS_MAX) |=> (cnt == $past(cnt) + 1'b1));

  a_r5_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_rise && !invert && end_pos <= start_pos) |=> !field_odd);

  a_r7_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(field_start) |-> $past(vs_pipe[1]));

endmodule

// File: tb/field_parity_detector_bench.sv
module field_parity_detector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_in = 1'b0, vsync_in = 1'b0, invert = 1'b0;
  logic [CNT_W-1:0] line_len = '0;
  logic [1:0] win_start_sel = '0, win_end_sel = '0;
  logic field_odd, field_start;

  int checks = 0, fails = 0, pulses = 0;
  bit expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  field_parity_detector #(.CNT_W(CNT_W)) u_field_parity_detector (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .line_len(line_len), .win_start_sel(win_start_sel), .win_end_sel(win_end_sel),
    .invert(invert), .field_odd(field_odd), .field_start(field_start));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && field_start) begin
      pulses++;
      if (expq.size() == 0) check("R8 unexpected pulse", 1, 0);
      else check("R4/R5/R6 parity", field_odd, expq.pop_front());
    end
  end

  task automatic field(input int d, input bit exp);
    expq.push_back(exp);
    @(negedge clk);
    hsync_in = 1'b1;
    for (int i = 0; i < d; i++) @(negedge clk);
    vsync_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 no early pulse", field_start, 0);
    @(negedge clk);
    check("R7 pulse latency", field_start, 1);
    @(negedge clk);
    check("R7 pulse width", field_start, 0);
    hsync_in = 1'b0;
    repeat (3) @(negedge clk);
    vsync_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic cfg(input int len, input int s, input int e, input bit inv);
    line_len = CNT_W'(len);
    win_start_sel = 2'(s);
    win_end_sel = 2'(e);
    invert = inv;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int p0;
    bit f0;
    repeat (3) @(negedge clk);
    check("R1 reset field_odd", field_odd, 0);
    check("R1 reset field_start", field_start, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", field_odd, 0);

    // R3/R4/R5: L=200 -> 25, 50, 100; window 25..100
    cfg(200, 1, 3, 0);
    field(25, 1);   // R4 start inclusive
    field(99, 1);   // R4
    field(100, 0);  // R5 end exclusive
    field(24, 0);   // R5
    field(0, 0);    // R2 coincident -> position 0
    // R6 invert
    cfg(200, 1, 3, 1);
    field(50, 0);
    field(10, 1);
    // R3 code 0 and 2: window 0..50
    cfg(200, 0, 2, 0);
    field(0, 1);
    field(49, 1);
    field(50, 0);
    // R5 empty window: start 100, end 25
    cfg(200, 3, 1, 0);
    field(60, 0);
    cfg(200, 3, 1, 1);
    field(60, 1);
    // R3 floor with L=255 -> 31, 63
    cfg(255, 1, 2, 0);
    field(31, 1);
    field(30, 0);
    field(63, 0);

    // R8/R9: hsync alone, vsync held high and falling give nothing
    p0 = pulses;
    f0 = field_odd;
    for (int k = 0; k < 3; k++) begin
      hsync_in = 1'b1; repeat (4) @(negedge clk);
      hsync_in = 1'b0; repeat (4) @(negedge clk);
    end
    vsync_in = 1'b1;
    vsync_in = 1'b1;
    repeat (2) @(negedge clk);
    expq.push_back(1'b0);
    repeat (10) @(negedge clk);
    check("R9 rising vsync gives pulse", pulses, p0 + 1);
    hsync_in = 1'b1; repeat (5) @(negedge clk);
    hsync_in = 1'b0; repeat (5) @(negedge clk);
    check("R8 vsync held high: no pulse", pulses, p0 + 1);
    vsync_in = 1'b0;
    repeat (10) @(negedge clk);
    check("R9 falling vsync: no pulse", pulses, p0 + 1);
    check("R8 field_odd held", field_odd, 0);
    check("R8 queue drained", expq.size(), 0);
    f0 = f0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule